// File: doc/BRIEF.md
# CAN Controller Mode and Command Control

This block is the register-side control unit of a CAN-style controller. A simple 8-bit register bus writes a mode register and a command register. The mode register holds four live bits: reset mode, listen-only, self-test and single-filter selection. These bits drive a separate protocol engine directly. A write to the command register never stores anything. Each 1 written to an action bit becomes a one-clock control pulse towards the engine or the receive FIFO.

The block tracks a transmit request from the moment it is accepted, through the engine's start handshake, to completion. This lets it refuse an abort once the frame is on the bus. It also turns a combined request-plus-abort write into a single-shot transfer. On the receive side it keeps two flags. The receive-ready flag says a received message is available. The overrun flag records that a message was lost. It also produces receive and transmit interrupt pulses. The receive side uses the FIFO's message count so that releasing one message sets the ready flag and the interrupt again when more messages are queued.

Reset mode is the quiet state. While reset mode is active, commands and engine events are ignored, the transmitter is idle and both receive flags are held clear.

Top module: `canmc_top`

## Requirements
- R1: After hardware reset, reset mode is 1 and every other mode bit is 0. Reading the mode address returns 0x01. All flags and pulse outputs are 0.
- R2: A write to the mode address (0) sets reset mode to bit 0 of the written data, visible on `mode_reset` one cycle after the write.
- R3: In a mode write, bit 1 (listen-only), bit 2 (self-test) and bit 3 (single filter) update their outputs only if reset mode was 1 before that write. Otherwise they keep their value. Data bits 4 to 7 are ignored.
- R4: `reg_rdata` is combinational. At address 0 it returns {4'b0000, single filter, self-test, listen-only, reset mode}. At address 1 (the command register) and at every other address it returns 0.
- R5: Command bit 0 (transmit request) is accepted only when reset mode is 0 and no transfer is pending or running. It gives a one-cycle `tx_go` in the cycle after the write. Command writes made while reset mode is 1 have no effect.
- R6: If command bits 0 and 1 are written together, `tx_one_shot` is 1 together with `tx_go`. At all other times `tx_one_shot` is 0.
- R7: Command bit 1 alone gives a one-cycle `tx_cancel` only while a request is pending and has not started. Once `tx_start` has been seen, including in the same cycle, or when no request exists, it has no effect.
- R8: Command bit 4 (self-reception) requests a transfer like bit 0, with `tx_self_rx` = 1 together with `tx_go`. With bit 1 also set, the transfer is single-shot.
- R9: Command bit 2 gives a one-cycle `rx_release`. The ready flag then becomes 1 if `rx_msg_count` was above 1 (or a message arrives in the same cycle), and 0 otherwise. If the flag becomes 1 and `rx_int_en` is 1, `rx_irq` pulses.
- R10: `rx_done` sets the ready flag. `rx_irq` pulses for it only if the flag was 0 before and `rx_int_en` is 1.
- R11: `rx_overrun` sets the overrun flag. Command bit 3 clears it. If both happen in the same cycle, the flag ends up set.
- R12: `tx_done` gives a one-cycle `tx_irq` when `tx_int_en` is 1, and returns the transmitter to idle.
- R13: In any cycle where reset mode is 1 before or after the clock edge, the transmitter returns to idle and the ready and overrun flags become 0. `rx_done`, `rx_overrun` and `tx_done` have no effect while reset mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tx_start | input | 1 | Engine has begun sending the frame on the bus |
| tx_done | input | 1 | Engine finished the transfer |
| rx_done | input | 1 | A new message was stored in the receive FIFO |
| rx_overrun | input | 1 | A received message was lost |
| rx_msg_count | input | CNT_W | Messages currently held in the receive FIFO |
| rx_int_en | input | 1 | Receive interrupt enable |
| tx_int_en | input | 1 | Transmit interrupt enable |
| mode_reset | output | 1 | Reset mode active |
| mode_listen | output | 1 | Listen-only (no acknowledge generation) |
| mode_selftest | output | 1 | Self-test (transfer completes without acknowledge) |
| mode_single_filter | output | 1 | 1 = single acceptance filter, 0 = dual |
| tx_go | output | 1 | Start-transfer pulse |
| tx_one_shot | output | 1 | No retransmission for this transfer (with `tx_go`) |
| tx_self_rx | output | 1 | Receive own frame (with `tx_go`) |
| tx_cancel | output | 1 | Drop the pending, not-yet-started transfer |
| rx_release | output | 1 | Pop the current message from the FIFO |
| rx_ready | output | 1 | Receive buffer holds a message |
| data_overrun | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
Mode writes are tried both from reset mode and from operating mode, with the reserved high data bits set. This separates a working configuration lock from a missing one. Command writes use each action bit alone, request and abort together, and self-reception with and without abort. Each is sent while the transmitter is idle, while a request is pending, and after the engine has started. This shows whether an abort races correctly against the start handshake and whether a busy transmitter refuses a second request. Release is tried with message counts of one and two, with interrupts on and off, and with overrun set and cleared in the same cycle. Reset mode is then entered with all state raised and with engine events still arriving, to show that everything is cleared and held.

// File: rtl/canmc_pkg.sv
package canmc_pkg;

    // bit positions inside the mode byte (read back in this order)
    localparam int MB_RESET   = 0;
    localparam int MB_LISTEN  = 1;
    localparam int MB_SELFTST = 2;
    localparam int MB_FILTER  = 3;

    // bit positions inside the command byte
    localparam int CB_TXREQ   = 0;
    localparam int CB_ABORT   = 1;
    localparam int CB_RELEASE = 2;
    localparam int CB_CLRDOR  = 3;
    localparam int CB_SELFRX  = 4;

    typedef struct packed {
        logic single_filter;
        logic self_test;
        logic listen_only;
        logic reset_mode;
    } mode_t;

    typedef struct packed {
        logic self_rx;
        logic clr_overrun;
        logic release_rx;
        logic abort;
        logic tx_req;
    } cmd_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_WAIT = 2'd1,
        TX_BUSY = 2'd2
    } tx_state_t;

    localparam mode_t MODE_AT_RESET = '{single_filter: 1'b0, self_test: 1'b0,
                                        listen_only: 1'b0, reset_mode: 1'b1};

    function automatic cmd_t decode_cmd(input logic [4:0] d);
        cmd_t c;
        c.tx_req      = d[CB_TXREQ];
        c.abort       = d[CB_ABORT];
        c.release_rx  = d[CB_RELEASE];
        c.clr_overrun = d[CB_CLRDOR];
        c.self_rx     = d[CB_SELFRX];
        return c;
    endfunction

    // configuration bits follow the data only when reset mode was already on
    function automatic mode_t merge_mode(input mode_t cur, input logic [3:0] d);
        mode_t r;
        r = cur;
        r.reset_mode = d[MB_RESET];
        if (cur.reset_mode) begin
            r.listen_only   = d[MB_LISTEN];
            r.self_test     = d[MB_SELFTST];
            r.single_filter = d[MB_FILTER];
        end
        return r;
    endfunction

    function automatic logic [7:0] mode_byte(input mode_t m);
        return {4'b0000, m};
    endfunction

endpackage

// File: rtl/canmc_mode_reg.sv
module canmc_mode_reg
    import canmc_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int MODE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        wdata_i,
    output mode_t             mode_o,
    output logic              quiet_o
);

    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

    mode_t mode_q;
    mode_t mode_d;
    logic  hit;

    assign hit = wr_i && (addr_i == MODE_A);

    always_comb begin
        mode_d = mode_q;
        if (hit) begin
            mode_d = merge_mode(mode_q, wdata_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_AT_RESET;
        end else begin
            mode_q <= mode_d;
        end
    end

    // quiet covers the cycle of entry as well as the whole reset-mode period
    assign quiet_o = mode_q.reset_mode | mode_d.reset_mode;
    assign mode_o  = mode_q;

    a_r3_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        !mode_q.reset_mode |=>
            $stable({mode_q.single_filter, mode_q.self_test, mode_q.listen_only}));

    a_r2_enter_reset: assert property (@(posedge clk) disable iff (rst)
        (hit && wdata_i[MB_RESET]) |=> mode_q.reset_mode);

    a_r2_leave_reset: assert property (@(posedge clk) disable iff (rst)
        (hit && !wdata_i[MB_RESET]) |=> !mode_q.reset_mode);

endmodule

// File: rtl/canmc_cmd_ctrl.sv
module canmc_cmd_ctrl
    import canmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr_i,
    input  cmd_t cmd_i,
    input  logic quiet_i,
    input  logic tx_start_i,
    input  logic tx_done_i,
    input  logic tx_int_en_i,
    output logic tx_go_o,
    output logic tx_one_shot_o,
    output logic tx_self_rx_o,
    output logic tx_cancel_o,
    output logic tx_irq_o,
    output logic release_o,
    output logic release_now_o,
    output logic clr_dor_o
);

    tx_state_t state_q;
    tx_state_t state_d;
    logic      act;
    logic      want_tx;
    logic      want_cancel;

    assign act     = cmd_wr_i && !quiet_i;
    assign want_tx = act && (cmd_i.tx_req || cmd_i.self_rx) && (state_q == TX_IDLE);
    // an abort loses against a start reported in the same cycle
    assign want_cancel = act && cmd_i.abort && !cmd_i.tx_req && !cmd_i.self_rx
                         && (state_q == TX_WAIT) && !tx_start_i;

    assign release_now_o = act && cmd_i.release_rx;
    assign clr_dor_o     = act && cmd_i.clr_overrun;

    always_comb begin
        state_d = state_q;
        if (quiet_i) begin
            state_d = TX_IDLE;
        end else begin
            case (state_q)
                TX_IDLE: if (want_tx) state_d = TX_WAIT;
                TX_WAIT: begin
                    if (want_cancel || tx_done_i) state_d = TX_IDLE;
                    else if (tx_start_i)          state_d = TX_BUSY;
                end
                TX_BUSY: if (tx_done_i) state_d = TX_IDLE;
                default: state_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= TX_IDLE;
            tx_go_o       <= 1'b0;
            tx_one_shot_o <= 1'b0;
            tx_self_rx_o  <= 1'b0;
            tx_cancel_o   <= 1'b0;
            tx_irq_o      <= 1'b0;
            release_o     <= 1'b0;
        end else begin
            state_q       <= state_d;
            tx_go_o       <= want_tx;
            tx_one_shot_o <= want_tx && cmd_i.abort;
            tx_self_rx_o  <= want_tx && cmd_i.self_rx;
            tx_cancel_o   <= want_cancel;
            tx_irq_o      <= !quiet_i && tx_done_i && tx_int_en_i;
            release_o     <= release_now_o;
        end
    end

    a_r7_go_cancel_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_go_o, tx_cancel_o}));

    a_r6_one_shot_with_go: assert property (@(posedge clk) disable iff (rst)
        tx_one_shot_o |-> tx_go_o);

    a_r8_self_rx_with_go: assert property (@(posedge clk) disable iff (rst)
        tx_self_rx_o |-> tx_go_o);

    a_r5_go_when_operating: assert property (@(posedge clk) disable iff (rst)
        tx_go_o |-> !$past(quiet_i));

    a_r7_no_cancel_after_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_BUSY) |=> !tx_cancel_o);

    a_r12_irq_from_done: assert property (@(posedge clk) disable iff (rst)
        tx_irq_o |-> $past(tx_done_i));

endmodule

// File: rtl/canmc_rx_status.sv
module canmc_rx_status #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             quiet_i,
    input  logic             release_now_i,
    input  logic             clr_dor_i,
    input  logic             rx_done_i,
    input  logic             overrun_i,
    input  logic [CNT_W-1:0] msg_count_i,
    input  logic             rx_int_en_i,
    output logic             rbs_o,
    output logic             dor_o,
    output logic             rx_irq_o
);

    localparam logic [CNT_W-1:0] ONE_MSG = CNT_W'(1);

    logic rbs_q, rbs_d;
    logic dor_q, dor_d;
    logic irq_d;
    logic more_waiting;

    assign more_waiting = msg_count_i > ONE_MSG;

    always_comb begin
        if (quiet_i) begin
            rbs_d = 1'b0;
            dor_d = 1'b0;
        end else begin
            rbs_d = release_now_i ? (more_waiting || rx_done_i) : (rbs_q || rx_done_i);
            // a fresh overrun wins over a clear in the same cycle
            dor_d = overrun_i || (dor_q && !clr_dor_i);
        end
        irq_d = !quiet_i && rx_int_en_i && rbs_d && (!rbs_q || release_now_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbs_q    <= 1'b0;
            dor_q    <= 1'b0;
            rx_irq_o <= 1'b0;
        end else begin
            rbs_q    <= rbs_d;
            dor_q    <= dor_d;
            rx_irq_o <= irq_d;
        end
    end

    assign rbs_o = rbs_q;
    assign dor_o = dor_q;

    a_r13_quiet_clears: assert property (@(posedge clk) disable iff (rst)
        quiet_i |=> (!rbs_q && !dor_q && !rx_irq_o));

    a_r11_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (overrun_i && !quiet_i) |=> dor_q);

    a_r9_irq_needs_ready: assert property (@(posedge clk) disable iff (rst)
        rx_irq_o |-> rbs_q);

    a_r10_arrival_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_done_i && !quiet_i) |=> rbs_q);

endmodule

// File: rtl/canmc_top.sv
module canmc_top
    import canmc_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int CNT_W     = 4,
    parameter int MODE_ADDR = 0,
    parameter int CMD_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic              rx_overrun,
    input  logic [CNT_W-1:0]  rx_msg_count,
    input  logic              rx_int_en,
    input  logic              tx_int_en,
    output logic              mode_reset,
    output logic              mode_listen,
    output logic              mode_selftest,
    output logic              mode_single_filter,
    output logic              tx_go,
    output logic              tx_one_shot,
    output logic              tx_self_rx,
    output logic              tx_cancel,
    output logic              rx_release,
    output logic              rx_ready,
    output logic              data_overrun,
    output logic              rx_irq,
    output logic              tx_irq
);

    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);

    mode_t mode;
    cmd_t  cmd;
    logic  quiet;
    logic  cmd_wr;
    logic  release_now;
    logic  clr_dor;
    logic  unused_reserved;

    assign unused_reserved = ^reg_wdata[7:5];
    assign cmd    = decode_cmd(reg_wdata[4:0]);
    assign cmd_wr = reg_wr && (reg_addr == CMD_A);

    canmc_mode_reg #(
        .ADDR_W    (ADDR_W),
        .MODE_ADDR (MODE_ADDR)
    ) i_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata[3:0]),
        .mode_o  (mode),
        .quiet_o (quiet)
    );

    canmc_cmd_ctrl i_cmd (
        .clk           (clk),
        .rst           (rst),
        .cmd_wr_i      (cmd_wr),
        .cmd_i         (cmd),
        .quiet_i       (quiet),
        .tx_start_i    (tx_start),
        .tx_done_i     (tx_done),
        .tx_int_en_i   (tx_int_en),
        .tx_go_o       (tx_go),
        .tx_one_shot_o (tx_one_shot),
        .tx_self_rx_o  (tx_self_rx),
        .tx_cancel_o   (tx_cancel),
        .tx_irq_o      (tx_irq),
        .release_o     (rx_release),
        .release_now_o (release_now),
        .clr_dor_o     (clr_dor)
    );

    canmc_rx_status #(
        .CNT_W (CNT_W)
    ) i_rx (
        .clk           (clk),
        .rst           (rst),
        .quiet_i       (quiet),
        .release_now_i (release_now),
        .clr_dor_i     (clr_dor),
        .rx_done_i     (rx_done),
        .overrun_i     (rx_overrun),
        .msg_count_i   (rx_msg_count),
        .rx_int_en_i   (rx_int_en),
        .rbs_o         (rx_ready),
        .dor_o         (data_overrun),
        .rx_irq_o      (rx_irq)
    );

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == MODE_A) begin
            reg_rdata = mode_byte(mode);
        end
    end

    assign mode_reset         = mode.reset_mode;
    assign mode_listen        = mode.listen_only;
    assign mode_selftest      = mode.self_test;
    assign mode_single_filter = mode.single_filter;

    a_r4_cmd_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == CMD_A) |-> (reg_rdata == 8'h00));

endmodule

// File: tb/test_canmc_top.sv
`timescale 1ns/1ps
module test_canmc_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_start = 1'b0, tx_done = 1'b0, rx_done = 1'b0, rx_overrun = 1'b0;
    logic [3:0] rx_msg_count = 4'd0;
    logic       rx_int_en = 1'b1, tx_int_en = 1'b1;
    logic       mode_reset, mode_listen, mode_selftest, mode_single_filter;
    logic       tx_go, tx_one_shot, tx_self_rx, tx_cancel, rx_release;
    logic       rx_ready, data_overrun, rx_irq, tx_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic [3:0] m_mode = 4'b0001;
    int         m_tx   = 0;   // 0 idle, 1 requested, 2 on the bus
    bit         m_rbs = 0, m_dor = 0;
    bit e_go, e_os, e_sr, e_can, e_rel, e_rirq, e_tirq;

    always #2 clk = ~clk;

    canmc_top i_canmc_top (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_start(tx_start), .tx_done(tx_done), .rx_done(rx_done),
        .rx_overrun(rx_overrun), .rx_msg_count(rx_msg_count),
        .rx_int_en(rx_int_en), .tx_int_en(tx_int_en),
        .mode_reset(mode_reset), .mode_listen(mode_listen),
        .mode_selftest(mode_selftest), .mode_single_filter(mode_single_filter),
        .tx_go(tx_go), .tx_one_shot(tx_one_shot), .tx_self_rx(tx_self_rx),
        .tx_cancel(tx_cancel), .rx_release(rx_release), .rx_ready(rx_ready),
        .data_overrun(data_overrun), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic cmp(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // advance one clock: model from present inputs, then compare every output
    task automatic step();
        logic [3:0] nm;
        bit hm, hc, q, acc;
        int ntx;
        bit nrbs, ndor;
        if (rst) begin
            nm = 4'b0001; ntx = 0; nrbs = 0; ndor = 0;
            e_go = 0; e_os = 0; e_sr = 0; e_can = 0; e_rel = 0; e_rirq = 0; e_tirq = 0;
        end else begin
            hm = reg_wr && reg_addr == 3'd0;
            hc = reg_wr && reg_addr == 3'd1;
            nm = m_mode;
            if (hm) begin
                nm[0] = reg_wdata[0];
                if (m_mode[0]) nm[3:1] = reg_wdata[3:1];
            end
            q     = m_mode[0] || nm[0];
            acc   = hc && !q;
            e_go  = acc && (reg_wdata[0] || reg_wdata[4]) && m_tx == 0;
            e_os  = e_go && reg_wdata[1];
            e_sr  = e_go && reg_wdata[4];
            e_can = acc && reg_wdata[1] && !reg_wdata[0] && !reg_wdata[4]
                    && m_tx == 1 && !tx_start;
            e_rel = acc && reg_wdata[2];
            ntx = m_tx;
            if (q) ntx = 0;
            else if (m_tx == 0 && e_go) ntx = 1;
            else if (m_tx == 1) begin
                if (e_can || tx_done) ntx = 0;
                else if (tx_start) ntx = 2;
            end else if (m_tx == 2 && tx_done) ntx = 0;
            e_tirq = !q && tx_done && tx_int_en;
            if (q) nrbs = 0;
            else if (e_rel) nrbs = (rx_msg_count > 1) || rx_done;
            else nrbs = m_rbs || rx_done;
            e_rirq = !q && rx_int_en && nrbs && (!m_rbs || e_rel);
            ndor = q ? 1'b0 : (rx_overrun || (m_dor && !(acc && reg_wdata[3])));
        end
        @(posedge clk);
        #1;
        m_mode = nm; m_tx = ntx; m_rbs = nrbs; m_dor = ndor;
        cmp("R2", "mode_reset", mode_reset, m_mode[0]);
        cmp("R3", "mode_listen", mode_listen, m_mode[1]);
        cmp("R3", "mode_selftest", mode_selftest, m_mode[2]);
        cmp("R3", "mode_single_filter", mode_single_filter, m_mode[3]);
        cmp("R4", "reg_rdata", reg_rdata, (reg_addr == 3'd0) ? {4'b0000, m_mode} : 8'h00);
        cmp("R5", "tx_go", tx_go, e_go);
        cmp("R6", "tx_one_shot", tx_one_shot, e_os);
        cmp("R8", "tx_self_rx", tx_self_rx, e_sr);
        cmp("R7", "tx_cancel", tx_cancel, e_can);
        cmp("R9", "rx_release", rx_release, e_rel);
        cmp("R9", "rx_irq", rx_irq, e_rirq);
        cmp("R10", "rx_ready", rx_ready, m_rbs);
        cmp("R11", "data_overrun", data_overrun, m_dor);
        cmp("R12", "tx_irq", tx_irq, e_tirq);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        reg_addr = 3'd0;
        idle(1);
        // R1: state after hardware reset
        cmp("R1", "mode byte after reset", reg_rdata, 8'h01);
        cmp("R1", "rx_ready after reset", rx_ready, 1'b0);

        // R3: configuration from reset mode, then locked in operating mode
        wr(3'd0, 8'h0E);
        cmp("R3", "config from reset", reg_rdata, 8'h0E);
        wr(3'd0, 8'h00);
        cmp("R3", "config locked", reg_rdata, 8'h0E);
        wr(3'd0, 8'hF1);
        cmp("R3", "upper bits ignored", reg_rdata, 8'h0F);
        wr(3'd0, 8'hF0);
        cmp("R3", "config cleared from reset", reg_rdata, 8'h00);

        // R5 / R12: plain transfer
        wr(3'd1, 8'h01);
        cmp("R5", "tx_go after request", tx_go, 1'b1);
        idle(1);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        tx_done = 1'b1; step(); tx_done = 1'b0;
        cmp("R12", "tx_irq on done", tx_irq, 1'b1);

        // R7: abort while pending
        wr(3'd1, 8'h01);
        wr(3'd1, 8'h02);
        cmp("R7", "cancel while pending", tx_cancel, 1'b1);

        // R7: abort after start
        wr(3'd1, 8'h01);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        wr(3'd1, 8'h02);
        cmp("R7", "no cancel after start", tx_cancel, 1'b0);
        tx_done = 1'b1; step(); tx_done = 1'b0;

        // R7: abort racing a start in the same cycle
        wr(3'd1, 8'h01);
        tx_start = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h02;
        step(); tx_start = 1'b0; reg_wr = 1'b0;
        cmp("R7", "start wins race", tx_cancel, 1'b0);
        tx_done = 1'b1; step(); tx_done = 1'b0;
        wr(3'd1, 8'h02);
        cmp("R7", "no cancel when idle", tx_cancel, 1'b0);

        // R6 and R5 busy refusal
        wr(3'd1, 8'h03);
        cmp("R6", "single shot", tx_one_shot, 1'b1);
        wr(3'd1, 8'h01);
        cmp("R5", "request ignored while pending", tx_go, 1'b0);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        tx_int_en = 1'b0;
        tx_done = 1'b1; step(); tx_done = 1'b0;
        cmp("R12", "tx_irq masked", tx_irq, 1'b0);
        tx_int_en = 1'b1;

        // R8: self reception in self-test mode
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h04);
        cmp("R8", "self-test active", mode_selftest, 1'b1);
        wr(3'd1, 8'h10);
        cmp("R8", "self rx flag", tx_self_rx, 1'b1);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        rx_msg_count = 4'd1;
        rx_done = 1'b1; tx_done = 1'b1; step(); rx_done = 1'b0; tx_done = 1'b0;
        cmp("R8", "both interrupts rx", rx_irq, 1'b1);
        cmp("R8", "both interrupts tx", tx_irq, 1'b1);
        wr(3'd1, 8'h04);
        rx_msg_count = 4'd0;
        wr(3'd1, 8'h12);
        cmp("R8", "self rx single shot", tx_one_shot, 1'b1);
        tx_done = 1'b1; step(); tx_done = 1'b0;

        // R10 / R9: receive flag and release
        rx_msg_count = 4'd1;
        rx_done = 1'b1; step(); rx_done = 1'b0;
        cmp("R10", "first arrival irq", rx_irq, 1'b1);
        rx_msg_count = 4'd2;
        rx_done = 1'b1; step(); rx_done = 1'b0;
        cmp("R10", "second arrival no irq", rx_irq, 1'b0);
        wr(3'd1, 8'h04);
        cmp("R9", "release with more queued irq", rx_irq, 1'b1);
        cmp("R9", "release with more queued flag", rx_ready, 1'b1);
        rx_msg_count = 4'd1;
        wr(3'd1, 8'h04);
        cmp("R9", "last release clears", rx_ready, 1'b0);
        rx_int_en = 1'b0;
        rx_done = 1'b1; step(); rx_done = 1'b0;
        cmp("R10", "irq masked", rx_irq, 1'b0);
        rx_int_en = 1'b1;
        rx_msg_count = 4'd3;
        wr(3'd1, 8'h04);

        // R11: overrun flag
        rx_overrun = 1'b1; step(); rx_overrun = 1'b0;
        wr(3'd1, 8'h08);
        cmp("R11", "overrun cleared", data_overrun, 1'b0);
        rx_overrun = 1'b1; step(); rx_overrun = 1'b0;
        rx_overrun = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h08;
        step(); rx_overrun = 1'b0; reg_wr = 1'b0;
        cmp("R11", "set wins over clear", data_overrun, 1'b1);

        // R13: entering reset mode clears everything and holds it
        rx_msg_count = 4'd1;
        rx_done = 1'b1; step(); rx_done = 1'b0;
        wr(3'd1, 8'h01);
        rx_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h01;
        step(); rx_done = 1'b0; reg_wr = 1'b0;
        cmp("R13", "ready cleared", rx_ready, 1'b0);
        cmp("R13", "overrun cleared", data_overrun, 1'b0);
        wr(3'd1, 8'h01);
        cmp("R5", "command ignored in reset mode", tx_go, 1'b0);
        rx_done = 1'b1; rx_overrun = 1'b1; tx_done = 1'b1;
        step(); rx_done = 1'b0; rx_overrun = 1'b0; tx_done = 1'b0;
        cmp("R13", "arrival ignored", rx_ready, 1'b0);
        cmp("R13", "tx done ignored", tx_irq, 1'b0);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h02);
        cmp("R13", "transfer dropped by reset", tx_cancel, 1'b0);

        // R4: read decode
        reg_addr = 3'd1; idle(1);
        cmp("R4", "command reads zero", reg_rdata, 8'h00);
        reg_addr = 3'd5; idle(1);
        cmp("R4", "unmapped reads zero", reg_rdata, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule